// File: doc/BRIEF.md
# Expansion ROM Discovery and Mapping Sequencer

This block runs on the host side during enumeration. After a start pulse it takes one device through the whole expansion ROM bring-up, using a configuration read/write master port. It reads the command register and saves the ROM base register. It then writes the sizing pattern and reads back the implemented mask. From that mask it works out the image size. It rounds a supplied free-memory pointer up to that size and checks the result against a supplied memory limit.

When the aligned window fits, the block programs the ROM base register with the decode-enable bit set. It then turns on memory-space decoding in the command register and fetches the first 16-bit word of the image through a separate memory read port to test for the signature. When the device implements no ROM, or when the window would cross the limit, the block writes the saved register value back and does not map anything. The results stay on the outputs until the next start: whether a ROM base register is implemented, the size, the mapped base and whether the signature was found.

Top module: `xrom_probe`

## Requirements
- R1: After reset, `busy`, `done`, `cfg_req`, `mem_req`, `present` and `sig_ok` are low, and `rom_size` and `rom_base` are zero.
- R2: A start pulse while idle begins a run. The block first reads offset 04h (command). It then reads the ROM base register, at offset 30h when `is_bridge` was low at start and at 38h when it was high. Each access holds `cfg_req`, `cfg_we`, `cfg_addr` and `cfg_wdata` steady until the cycle in which `cfg_ack` is high. `busy` is high from the cycle after start up to and including the `done` cycle.
- R3: The third access writes FFFF_F800h to the ROM base register. The fourth access reads that register back. Only bits 31:11 of the readback are kept as the mask.
- R4: When the mask is zero, the next access writes back the value saved from the second access. The run then ends with `present`, `sig_ok`, `rom_size` and `rom_base` all zero, and no memory read is issued.
- R5: When the mask is nonzero, `present` is 1 and `rom_size` is the bitwise inverse of the mask plus one. For example, FFFE_0000h gives 0002_0000h.
- R6: The chosen base is the free pointer rounded up to the next multiple of the size, computed as (pointer + size - 1) AND NOT (size - 1), with no truncation to 32 bits.
- R7: The window fits when base + size is at most `mem_limit`, which is an exclusive end address. When it does not fit, the saved register value is written back, no memory read is issued, `rom_base` stays zero and `sig_ok` is 0, while `present` and `rom_size` are still reported.
- R8: When the window fits, the block writes the base OR 1 to the ROM base register (bit 0 is the decode enable). It then writes the saved command value OR 0000_0002h to offset 04h (bit 1 is memory space). It then issues one memory read at the base address and reports that base on `rom_base`.
- R9: `mem_rdata[7:0]` is the byte at the base address and `mem_rdata[15:8]` is the next byte. `sig_ok` is 1 only when they are 55h and AAh, that is, when the word equals 16'hAA55.
- R10: `done` is a single-cycle pulse that ends each run. The results hold until the next start. A start pulse during a run has no effect on it. `cfg_req` and `mem_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle |
| is_bridge | input | 1 | Selects the bridge offset of the ROM base register |
| free_ptr | input | 32 | Lowest free address available for mapping |
| mem_limit | input | 32 | Exclusive end of the usable address space |
| cfg_req | output | 1 | Configuration access request |
| cfg_we | output | 1 | 1 = write, 0 = read |
| cfg_addr | output | 8 | Configuration register offset |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_ack | input | 1 | Access complete; read data valid |
| cfg_rdata | input | 32 | Configuration read data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Memory read complete |
| mem_rdata | input | 16 | First ROM word, lower address in bits 7:0 |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| present | output | 1 | A ROM base register is implemented |
| sig_ok | output | 1 | Signature found at the mapped base |
| rom_size | output | 32 | Image size in bytes |
| rom_base | output | 32 | Mapped base, zero when not mapped |

## Verification
The bench builds the block with its default signature word and memory-space bit. Its device model answers configuration accesses after two wait cycles and memory reads after three, so every hold-until-acknowledge path is exercised. Each run varies the implemented mask, from the smallest 2 KB window up to 1 MB and the empty mask. It also varies the function type, whether the pointer is already aligned, an exact fit against the limit, a rounded base that crosses it, and a byte-swapped signature. Together these reach every terminal path of the sequencer.

// File: rtl/xrom_pkg.sv
package xrom_pkg;
    localparam int DW      = 32;
    localparam int CFG_AW  = 8;
    localparam logic [CFG_AW-1:0] OFF_CMD     = 8'h04;
    localparam logic [CFG_AW-1:0] OFF_BAR_DEV = 8'h30;
    localparam logic [CFG_AW-1:0] OFF_BAR_BRG = 8'h38;
    localparam logic [DW-1:0]     SIZE_PROBE  = 32'hFFFF_F800;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_CMD, S_RD_BAR, S_WR_PROBE, S_RD_MASK, S_DECIDE,
        S_WR_MAP, S_WR_CMD, S_RD_ROM, S_RESTORE, S_FIN
    } seq_state_t;

    typedef struct packed {
        logic              req;
        logic              we;
        logic [CFG_AW-1:0] addr;
        logic [DW-1:0]     wdata;
    } cfg_cmd_t;

    function automatic logic [DW-1:0] keep_mask(input logic [DW-1:0] rb);
        return rb & SIZE_PROBE;
    endfunction
endpackage

// File: rtl/xrom_sizer.sv
module xrom_sizer
    import xrom_pkg::*;
(
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] ptr,
    input  logic [DW-1:0] limit,
    output logic [DW-1:0] size,
    output logic [DW-1:0] base,
    output logic          fits
);
    logic [DW:0] sz_w, base_w, end_w;

    always_comb begin
        size   = ~mask + {{(DW-1){1'b0}}, 1'b1};
        sz_w   = {1'b0, size};
        base_w = ({1'b0, ptr} + sz_w - {{DW{1'b0}}, 1'b1}) & ~(sz_w - {{DW{1'b0}}, 1'b1});
        end_w  = base_w + sz_w;
        fits   = (mask != '0) && (end_w <= {1'b0, limit});
        base   = base_w[DW-1:0];
    end
endmodule

// File: rtl/xrom_seq.sv
module xrom_seq
    import xrom_pkg::*;
#(
    parameter logic [15:0] SIG_WORD    = 16'hAA55,
    parameter int          CMD_MEM_BIT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_bridge,
    input  logic [DW-1:0]     free_ptr,
    input  logic [DW-1:0]     mem_limit,
    input  logic              cfg_ack,
    input  logic [DW-1:0]     cfg_rdata,
    input  logic              mem_ack,
    input  logic [15:0]       mem_rdata,
    input  logic [DW-1:0]     calc_size,
    input  logic [DW-1:0]     calc_base,
    input  logic              calc_fits,
    output cfg_cmd_t          cfg_o,
    output logic              mem_req,
    output logic [DW-1:0]     mem_addr,
    output logic [DW-1:0]     mask_q,
    output logic [DW-1:0]     ptr_q,
    output logic [DW-1:0]     lim_q,
    output logic              busy,
    output logic              done,
    output logic              present,
    output logic              sig_ok,
    output logic [DW-1:0]     rom_size,
    output logic [DW-1:0]     rom_base
);
    localparam logic [DW-1:0] MEM_EN = DW'(1) << CMD_MEM_BIT;

    seq_state_t        st;
    logic [CFG_AW-1:0] bar_off_q;
    logic [DW-1:0]     cmd_q, orig_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            bar_off_q <= OFF_BAR_DEV;
            cmd_q     <= '0;
            orig_q    <= '0;
            mask_q    <= '0;
            ptr_q     <= '0;
            lim_q     <= '0;
            present   <= 1'b0;
            sig_ok    <= 1'b0;
            rom_size  <= '0;
            rom_base  <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (start) begin
                    bar_off_q <= is_bridge ? OFF_BAR_BRG : OFF_BAR_DEV;
                    ptr_q     <= free_ptr;
                    lim_q     <= mem_limit;
                    present   <= 1'b0;
                    sig_ok    <= 1'b0;
                    rom_size  <= '0;
                    rom_base  <= '0;
                    st        <= S_RD_CMD;
                end
                S_RD_CMD:   if (cfg_ack) begin cmd_q  <= cfg_rdata; st <= S_RD_BAR;   end
                S_RD_BAR:   if (cfg_ack) begin orig_q <= cfg_rdata; st <= S_WR_PROBE; end
                S_WR_PROBE: if (cfg_ack) st <= S_RD_MASK;
                S_RD_MASK:  if (cfg_ack) begin mask_q <= keep_mask(cfg_rdata); st <= S_DECIDE; end
                S_DECIDE: begin
                    if (mask_q == '0) begin
                        st <= S_RESTORE;
                    end else begin
                        present  <= 1'b1;
                        rom_size <= calc_size;
                        if (calc_fits) begin
                            rom_base <= calc_base;
                            st       <= S_WR_MAP;
                        end else begin
                            st <= S_RESTORE;
                        end
                    end
                end
                S_WR_MAP:  if (cfg_ack) st <= S_WR_CMD;
                S_WR_CMD:  if (cfg_ack) st <= S_RD_ROM;
                S_RD_ROM:  if (mem_ack) begin sig_ok <= (mem_rdata == SIG_WORD); st <= S_FIN; end
                S_RESTORE: if (cfg_ack) st <= S_FIN;
                S_FIN:     st <= S_IDLE;
                default:   st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        cfg_o = '{req: 1'b0, we: 1'b0, addr: bar_off_q, wdata: '0};
        unique case (st)
            S_RD_CMD:   begin cfg_o.req = 1'b1; cfg_o.addr = OFF_CMD; end
            S_RD_BAR,
            S_RD_MASK:  cfg_o.req = 1'b1;
            S_WR_PROBE: begin cfg_o.req = 1'b1; cfg_o.we = 1'b1; cfg_o.wdata = SIZE_PROBE; end
            S_WR_MAP:   begin cfg_o.req = 1'b1; cfg_o.we = 1'b1; cfg_o.wdata = rom_base | DW'(1); end
            S_WR_CMD:   begin cfg_o.req = 1'b1; cfg_o.we = 1'b1; cfg_o.addr = OFF_CMD;
                              cfg_o.wdata = cmd_q | MEM_EN; end
            S_RESTORE:  begin cfg_o.req = 1'b1; cfg_o.we = 1'b1; cfg_o.wdata = orig_q; end
            default: ;
        endcase
    end

    assign mem_req  = (st == S_RD_ROM);
    assign mem_addr = rom_base;
    assign busy     = (st != S_IDLE);
    assign done     = (st == S_FIN);
endmodule

// File: rtl/xrom_probe.sv
module xrom_probe
    import xrom_pkg::*;
#(
    parameter logic [15:0] SIG_WORD    = 16'hAA55,
    parameter int          CMD_MEM_BIT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_bridge,
    input  logic [DW-1:0]     free_ptr,
    input  logic [DW-1:0]     mem_limit,
    output logic              cfg_req,
    output logic              cfg_we,
    output logic [CFG_AW-1:0] cfg_addr,
    output logic [DW-1:0]     cfg_wdata,
    input  logic              cfg_ack,
    input  logic [DW-1:0]     cfg_rdata,
    output logic              mem_req,
    output logic [DW-1:0]     mem_addr,
    input  logic              mem_ack,
    input  logic [15:0]       mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              present,
    output logic              sig_ok,
    output logic [DW-1:0]     rom_size,
    output logic [DW-1:0]     rom_base
);
    cfg_cmd_t      cfg_o;
    logic [DW-1:0] mask_q, ptr_q, lim_q, calc_size, calc_base;
    logic          calc_fits;

    xrom_sizer u_sizer (
        .mask (mask_q),
        .ptr  (ptr_q),
        .limit(lim_q),
        .size (calc_size),
        .base (calc_base),
        .fits (calc_fits)
    );

    xrom_seq #(.SIG_WORD(SIG_WORD), .CMD_MEM_BIT(CMD_MEM_BIT)) u_seq (
        .clk, .rst, .start, .is_bridge, .free_ptr, .mem_limit,
        .cfg_ack, .cfg_rdata, .mem_ack, .mem_rdata,
        .calc_size, .calc_base, .calc_fits,
        .cfg_o, .mem_req, .mem_addr, .mask_q, .ptr_q, .lim_q,
        .busy, .done, .present, .sig_ok, .rom_size, .rom_base
    );

    assign cfg_req   = cfg_o.req;
    assign cfg_we    = cfg_o.we;
    assign cfg_addr  = cfg_o.addr;
    assign cfg_wdata = cfg_o.wdata;
endmodule

// File: rtl/xrom_probe_chk.sv
module xrom_probe_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        cfg_req,
    input logic        cfg_we,
    input logic [7:0]  cfg_addr,
    input logic [31:0] cfg_wdata,
    input logic        cfg_ack,
    input logic        mem_req,
    input logic        busy,
    input logic        done,
    input logic        present,
    input logic        sig_ok,
    input logic [31:0] rom_size,
    input logic [31:0] rom_base
);
    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && !cfg_ack) |=> (cfg_req && $stable(cfg_we) && $stable(cfg_addr) && $stable(cfg_wdata)));

    a_r6_base_aligned: assert property (@(posedge clk) disable iff (rst)
        (done && rom_base != 32'd0) |-> ((rom_base & (rom_size - 32'd1)) == 32'd0));

    a_r4_absent_clean: assert property (@(posedge clk) disable iff (rst)
        (done && !present) |-> (!sig_ok && rom_size == 32'd0 && rom_base == 32'd0));

    a_r9_sig_needs_map: assert property (@(posedge clk) disable iff (rst)
        (done && sig_ok) |-> (present && rom_base != 32'd0));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_one_port: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cfg_req, mem_req}));

    a_r10_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> (!cfg_req && !mem_req));
endmodule

bind xrom_probe xrom_probe_chk u_chk (
    .clk, .rst, .start, .cfg_req, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_ack,
    .mem_req, .busy, .done, .present, .sig_ok, .rom_size, .rom_base
);

// File: tb/xrom_probe_bench.sv
module xrom_probe_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CFG_LAT    = 2;
    localparam int MEM_LAT    = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, is_bridge = 1'b0;
    logic [31:0] free_ptr = '0, mem_limit = '0;
    logic        cfg_req, cfg_we;
    logic [7:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        cfg_ack = 1'b0;
    logic [31:0] cfg_rdata = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        busy, done, present, sig_ok;
    logic [31:0] rom_size, rom_base;

    always #(CLK_PERIOD/2) clk = ~clk;

    xrom_probe u_xrom_probe (
        .clk, .rst, .start, .is_bridge, .free_ptr, .mem_limit,
        .cfg_req, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_ack, .cfg_rdata,
        .mem_req, .mem_addr, .mem_ack, .mem_rdata,
        .busy, .done, .present, .sig_ok, .rom_size, .rom_base
    );

    typedef struct { logic we; logic [7:0] addr; logic [31:0] data; string tag; } xact_t;
    xact_t exp_q[$];

    int n_cmp = 0, n_bad = 0;
    logic [31:0] dev_cmd, dev_bar, dev_mask;
    logic [15:0] dev_sig;
    logic        mem_expected;
    logic [31:0] exp_mem_addr;
    int          mem_seen;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic we, input logic [7:0] a, input logic [31:0] d, input string tag);
        xact_t x;
        x.we = we; x.addr = a; x.data = d; x.tag = tag;
        exp_q.push_back(x);
    endtask

    // Device responder and scoreboard monitor
    initial begin
        int cw = 0, mw = 0;
        forever begin
            @(negedge clk);
            if (cfg_ack) cfg_ack = 1'b0;
            else if (cfg_req) begin
                if (cw >= CFG_LAT) begin
                    xact_t x;
                    cw = 0;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2 unexpected cfg access", {24'd0, cfg_addr}, 32'd0);
                    end else begin
                        x = exp_q.pop_front();
                        check(cfg_we == x.we && cfg_addr == x.addr && (!x.we || cfg_wdata == x.data),
                              x.tag, cfg_we ? cfg_wdata : {24'd0, cfg_addr}, x.we ? x.data : {24'd0, x.addr});
                    end
                    if (cfg_we) begin
                        if (cfg_addr == 8'h04) dev_cmd = cfg_wdata;
                        else dev_bar = (cfg_wdata == 32'hFFFF_F800) ? dev_mask : cfg_wdata;
                    end else begin
                        cfg_rdata = (cfg_addr == 8'h04) ? dev_cmd : dev_bar;
                    end
                    cfg_ack = 1'b1;
                end else cw++;
            end
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (mw >= MEM_LAT) begin
                    mw = 0;
                    mem_seen++;
                    check(mem_expected, "R8 memory read only when mapped", mem_addr, 32'd0);
                    check(mem_addr == exp_mem_addr, "R8 memory read address", mem_addr, exp_mem_addr);
                    mem_rdata = dev_sig;
                    mem_ack   = 1'b1;
                end else mw++;
            end
        end
    end

    task automatic run_case(input string name, input logic brg, input logic [31:0] mask,
                            input logic [31:0] orig, input logic [31:0] cmd,
                            input logic [31:0] ptr, input logic [31:0] lim,
                            input logic [15:0] sig, input bit dup_start);
        logic [7:0]  off;
        logic [32:0] sz, bs;
        logic        fits, exp_sig;
        logic [31:0] exp_size, exp_base;
        int          cyc;
        off = brg ? 8'h38 : 8'h30;
        dev_mask = mask; dev_bar = orig; dev_cmd = cmd; dev_sig = sig;
        sz   = {1'b0, ~mask} + 33'd1;
        bs   = (({1'b0, ptr} + sz - 33'd1) / sz) * sz;
        fits = (mask != 0) && (bs + sz <= {1'b0, lim});
        exp_size = (mask != 0) ? sz[31:0] : 32'd0;
        exp_base = fits ? bs[31:0] : 32'd0;
        exp_sig  = fits && (sig == 16'hAA55);
        mem_expected = fits; exp_mem_addr = exp_base; mem_seen = 0;
        push(1'b0, 8'h04, 32'd0, "R2 command read");
        push(1'b0, off, 32'd0, "R2 ROM BAR read at function-type offset");
        push(1'b1, off, 32'hFFFF_F800, "R3 sizing write");
        push(1'b0, off, 32'd0, "R3 mask readback");
        if (fits) begin
            push(1'b1, off, bs[31:0] | 32'd1, "R8 map write with enable");
            push(1'b1, 8'h04, cmd | 32'h2, "R8 memory space write");
        end else begin
            push(1'b1, off, orig, (mask == 0) ? "R4 restore original BAR" : "R7 restore original BAR");
        end
        is_bridge = brg; free_ptr = ptr; mem_limit = lim;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", {31'd0, busy}, 32'd1);
        if (dup_start) begin
            repeat (4) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        cyc = 0;
        while (!done && cyc < 500) begin
            check(busy == 1'b1, "R2 busy held until done", {31'd0, busy}, 32'd1);
            @(negedge clk); cyc++;
        end
        $display("case %s", name);
        check(done == 1'b1, "R10 done reached", {31'd0, done}, 32'd1);
        check(present == (mask != 0), "R5 present", {31'd0, present}, {31'd0, mask != 0});
        check(rom_size == exp_size, "R5 size", rom_size, exp_size);
        check(rom_base == exp_base, "R6 R7 base", rom_base, exp_base);
        check(sig_ok == exp_sig, "R9 signature flag", {31'd0, sig_ok}, {31'd0, exp_sig});
        check(exp_q.size() == 0, "R2 all config accesses seen", exp_q.size(), 32'd0);
        check(mem_seen == (fits ? 1 : 0), "R8 memory read count", mem_seen, fits ? 32'd1 : 32'd0);
        @(negedge clk);
        check(!done && !busy, "R10 done single pulse", {30'd0, done, busy}, 32'd0);
        repeat (3) @(negedge clk);
        check(rom_size == exp_size && rom_base == exp_base && sig_ok == exp_sig,
              "R10 results held", rom_base, exp_base);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !cfg_req && !mem_req && !present && !sig_ok &&
              rom_size == 0 && rom_base == 0, "R1 reset state",
              {26'd0, busy, done, cfg_req, mem_req, present, sig_ok}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        run_case("128K map",     1'b0, 32'hFFFE_0000, 32'h0,         32'h4, 32'h1234_5678, 32'hF000_0000, 16'hAA55, 1'b1);
        run_case("2K bridge",    1'b1, 32'hFFFF_F800, 32'h0,         32'h2, 32'h0000_0800, 32'hF000_0000, 16'h55AA, 1'b0);
        run_case("absent",       1'b0, 32'h0,         32'hDEAD_0000, 32'h4, 32'h0010_0000, 32'hF000_0000, 16'hAA55, 1'b0);
        run_case("over limit",   1'b0, 32'hFFF0_0000, 32'h1234_5000, 32'h6, 32'hFFE0_0001, 32'hFFFF_FFFF, 16'hAA55, 1'b0);
        run_case("exact fit",    1'b1, 32'hFFFF_0000, 32'h0,         32'h0, 32'h0001_0000, 32'h0002_0000, 16'hAA55, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule